// File: doc/BRIEF.md
# Sync Activity Hysteresis Monitor

This block judges whether an incoming video source is live from status samples taken once per frame. At each frame strobe it receives a raw sync-detected bit, a measured total line count, a clocks-per-line value split across two bytes, and a progressive/interlaced flag. A signed hysteresis counter filters the raw sync bit and the line-count validity check into a debounced live state. A one-cycle pulse marks each change of that state.

A second path tracks whether the measured timing stays the same from frame to frame. When the timing has held for a set number of frames, it raises a mode-change pulse. Downstream control logic uses this pulse to apply the new timing. While the source is not live, the raw sync-mode bits are masked to zero so that stale mode information cannot leak out.

The counter needs a short run of good frames to declare the source live. It needs a longer run of bad frames to declare it lost. This asymmetry rides through brief sync dropouts while still reacting promptly to a real source.

Top module: `sync_live_monitor`

## Requirements
- R1: A line count is valid only when it is at least 200 for a progressive sample (`prog`=1) or at least 400 for an interlaced sample (`prog`=0). A sample is good when `sync_seen`=1 and its line count is valid.
- R2: While not live, the 4th consecutive good strobe sets `live`. The first three good strobes only advance the counter. `live_chg` is high during the cycle of that 4th strobe, and `live` reads 1 from the next cycle.
- R3: While live, the 6th consecutive bad strobe clears `live`, with `live_chg` high during that strobe's cycle. A bad strobe is one whose sample is not good.
- R4: A strobe that neither advances toward acquisition nor advances toward loss returns the counter to zero. A later run must then start over from its full length.
- R5: Without a strobe, `live`, the stored timing and the stable state do not change, and `live_chg` and `mode_chg` stay low.
- R6: `sync_mode` equals `sync_mode_raw` while live and is 0 while not live.
- R7: The clocks-per-line value is 12 bits: bits 11:8 come from `cpl_hi[3:0]` and bits 7:0 come from `cpl_lo`. `cpl_hi[7:4]` is ignored.
- R8: On a strobe with a valid line count, the new line count, clocks-per-line value and scan flag are stored. If any of them differs from the stored value, the stable count returns to 0. Otherwise the count increments until it reaches the threshold of 1.
- R9: When the stable count reaches the threshold, `mode_chg` is high during that strobe's cycle and `stable` reads 1 from the next cycle. Further matching strobes raise no pulse.
- R10: A strobe with an invalid line count leaves the stored timing and the stable state unchanged.
- R11: After reset, `live`=0, `stable`=0, and the stored line count, clocks-per-line value and scan flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe that marks a new per-frame sample |
| sync_seen | input | 1 | Raw sync-detected bit for this frame |
| prog | input | 1 | 1 = progressive, 0 = interlaced |
| line_total | input | 11 | Measured total lines per frame |
| cpl_hi | input | 8 | High byte of clocks per line; only the low nibble is used |
| cpl_lo | input | 8 | Low byte of clocks per line |
| sync_mode_raw | input | 2 | Raw sync-mode bits |
| live | output | 1 | Debounced source-active state |
| live_chg | output | 1 | Pulse during the strobe on which `live` flips |
| sync_mode | output | 2 | Sync-mode bits, masked to zero while not live |
| stor_lines | output | 11 | Stored line count |
| stor_cpl | output | 12 | Stored clocks-per-line value |
| stor_prog | output | 1 | Stored scan flag |
| stable | output | 1 | Timing has been unchanged for the threshold count of frames |
| mode_chg | output | 1 | Pulse during the strobe on which the timing becomes stable |

## Verification
Some properties are checked on every cycle: state only moves on a strobe, each activity pulse is followed by a flip of `live` and every flip is preceded by a pulse, masked sync-mode bits are never nonzero while not live, and a mode-change pulse is always followed by `stable`. Other behaviour depends on run lengths of frames, so only the directed scenarios can show it. This covers the exact strobe count of the 4-frame acquisition and 6-frame loss, the counter clearing after an interruption, and the 199/200 and 399/400 validity boundaries. It also covers ignoring the upper nibble of the high byte and leaving stored timing untouched by an invalid sample.

// File: rtl/sah_pkg.sv
package sah_pkg;

    // Counter action chosen for one strobe
    typedef enum logic [1:0] {
        HOP_CLEAR = 2'd0,
        HOP_UP    = 2'd1,
        HOP_DOWN  = 2'd2,
        HOP_FLIP  = 2'd3
    } hyst_op_e;

    // Snapshot of the measured timing of one frame
    typedef struct packed {
        logic        prog;
        logic [10:0] lines;
        logic [11:0] cpl;
    } timing_t;

    // Line-count validity depends on the scan type
    function automatic logic lines_ok(input logic prog_i, input int unsigned lines_i,
                                      input int unsigned min_prog, input int unsigned min_intl);
        return prog_i ? (lines_i >= min_prog) : (lines_i >= min_intl);
    endfunction

endpackage

// File: rtl/sah_hyst.sv
module sah_hyst
    import sah_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int ACQ_TH = 3,
    parameter int LOSS_TH = -5
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic good,
    output logic live,
    output logic flip
);
    localparam logic signed [CNT_W-1:0] ACQ_S  = CNT_W'(ACQ_TH);
    localparam logic signed [CNT_W-1:0] LOSS_S = CNT_W'(LOSS_TH);

    logic signed [CNT_W-1:0] cnt_q;
    hyst_op_e op;

    always_comb begin
        if (!live && good)
            op = (cnt_q >= ACQ_S) ? HOP_FLIP : HOP_UP;
        else if (live && !good)
            op = (cnt_q <= LOSS_S) ? HOP_FLIP : HOP_DOWN;
        else
            op = HOP_CLEAR;
    end

    assign flip = stb && (op == HOP_FLIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            live  <= 1'b0;
            cnt_q <= '0;
        end else if (stb) begin
            unique case (op)
                HOP_FLIP: begin
                    live  <= ~live;
                    cnt_q <= '0;
                end
                HOP_UP:   cnt_q <= cnt_q + 1'b1;
                HOP_DOWN: cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sah_stab.sv
module sah_stab
    import sah_pkg::*;
#(
    parameter int STABLE_TH = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    stb,
    input  logic    valid,
    input  timing_t cur,
    output timing_t stor,
    output logic    stable,
    output logic    mode_chg
);
    localparam int SC_W = (STABLE_TH < 1) ? 1 : $clog2(STABLE_TH + 1);
    localparam logic [SC_W-1:0] TH_V = SC_W'(STABLE_TH);

    logic [SC_W-1:0] scnt_q;
    logic            differ;
    logic            take;

    assign take     = stb && valid;
    assign differ   = (cur != stor);
    assign mode_chg = take && !differ && (scnt_q != TH_V) && ((scnt_q + 1'b1) == TH_V);
    assign stable   = (scnt_q == TH_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            stor   <= '0;
            scnt_q <= '0;
        end else if (take) begin
            stor <= cur;
            if (differ)
                scnt_q <= '0;
            else if (scnt_q != TH_V)
                scnt_q <= scnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sync_live_monitor.sv
module sync_live_monitor
    import sah_pkg::*;
#(
    parameter int LINE_W    = 11,
    parameter int BYTE_W    = 8,
    parameter int HI_USED   = 4,
    parameter int MODE_W    = 2,
    parameter int CNT_W     = 4,
    parameter int ACQ_TH    = 3,
    parameter int LOSS_TH   = -5,
    parameter int MIN_PROG  = 200,
    parameter int MIN_INTL  = 400,
    parameter int STABLE_TH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              sync_seen,
    input  logic              prog,
    input  logic [LINE_W-1:0] line_total,
    input  logic [BYTE_W-1:0] cpl_hi,
    input  logic [BYTE_W-1:0] cpl_lo,
    input  logic [MODE_W-1:0] sync_mode_raw,
    output logic              live,
    output logic              live_chg,
    output logic [MODE_W-1:0] sync_mode,
    output logic [LINE_W-1:0] stor_lines,
    output logic [HI_USED+BYTE_W-1:0] stor_cpl,
    output logic              stor_prog,
    output logic              stable,
    output logic              mode_chg
);
    localparam int CPL_W = HI_USED + BYTE_W;

    logic             valid;
    logic             good;
    logic [CPL_W-1:0] cpl;
    logic             unused_hi_bits;
    timing_t          cur_t;
    timing_t          stor_t;

    assign cpl            = {cpl_hi[HI_USED-1:0], cpl_lo};
    assign unused_hi_bits = ^cpl_hi[BYTE_W-1:HI_USED];

    assign valid = lines_ok(prog, 32'(line_total), MIN_PROG, MIN_INTL);
    assign good  = sync_seen && valid;

    assign cur_t.prog  = prog;
    assign cur_t.lines = 11'(line_total);
    assign cur_t.cpl   = 12'(cpl);

    sah_hyst #(
        .CNT_W  (CNT_W),
        .ACQ_TH (ACQ_TH),
        .LOSS_TH(LOSS_TH)
    ) u_hyst (
        .clk (clk),
        .rst (rst),
        .stb (frame_stb),
        .good(good),
        .live(live),
        .flip(live_chg)
    );

    sah_stab #(
        .STABLE_TH(STABLE_TH)
    ) u_stab (
        .clk     (clk),
        .rst     (rst),
        .stb     (frame_stb),
        .valid   (valid),
        .cur     (cur_t),
        .stor    (stor_t),
        .stable  (stable),
        .mode_chg(mode_chg)
    );

    assign sync_mode  = live ? sync_mode_raw : '0;
    assign stor_lines = LINE_W'(stor_t.lines);
    assign stor_cpl   = CPL_W'(stor_t.cpl);
    assign stor_prog  = stor_t.prog;
endmodule

// File: rtl/sync_live_monitor_chk.sv
module sync_live_monitor_chk #(
    parameter int LINE_W = 11,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input logic              live,
    input logic              live_chg,
    input logic [MODE_W-1:0] sync_mode,
    input logic [LINE_W-1:0] stor_lines,
    input logic              stable,
    input logic              mode_chg
);
    // R5: pulses only appear with a strobe
    assert_chg_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (live_chg || mode_chg) |-> frame_stb);

    // R5: state holds between strobes
    assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> ($stable(live) && $stable(stor_lines) && $stable(stable)));

    // R2, R3: an activity pulse is followed by a flip of live
    assert_pulse_flips_R2: assert property (@(posedge clk) disable iff (rst)
        live_chg |=> (live != $past(live)));

    // R3: every flip of live was announced by a pulse
    assert_flip_announced_R3: assert property (@(posedge clk) disable iff (rst)
        (live != $past(live)) |-> $past(live_chg));

    // R6: nonzero mode bits only while live
    assert_mode_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (sync_mode != '0) |-> live);

    // R9: a mode-change pulse leads to the stable state
    assert_mode_chg_stable_R9: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> stable);
endmodule

bind sync_live_monitor sync_live_monitor_chk #(
    .LINE_W(LINE_W),
    .MODE_W(MODE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .live      (live),
    .live_chg  (live_chg),
    .sync_mode (sync_mode),
    .stor_lines(stor_lines),
    .stable    (stable),
    .mode_chg  (mode_chg)
);

// File: tb/sync_live_monitor_bench.sv
module sync_live_monitor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        sync_seen = 1'b0;
    logic        prog = 1'b0;
    logic [10:0] line_total = '0;
    logic [7:0]  cpl_hi = '0;
    logic [7:0]  cpl_lo = '0;
    logic [1:0]  sync_mode_raw = 2'b11;
    logic        live, live_chg, stor_prog, stable, mode_chg;
    logic [1:0]  sync_mode;
    logic [10:0] stor_lines;
    logic [11:0] stor_cpl;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic got_chg, got_mchg;

    always #4 clk = ~clk;

    sync_live_monitor u_sync_live_monitor (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .sync_seen(sync_seen),
        .prog(prog), .line_total(line_total), .cpl_hi(cpl_hi), .cpl_lo(cpl_lo),
        .sync_mode_raw(sync_mode_raw), .live(live), .live_chg(live_chg),
        .sync_mode(sync_mode), .stor_lines(stor_lines), .stor_cpl(stor_cpl),
        .stor_prog(stor_prog), .stable(stable), .mode_chg(mode_chg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One frame sample; pulses captured during the strobe cycle
    task automatic frame(input logic s, input logic p, input int lines,
                         input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        sync_seen = s; prog = p; line_total = 11'(lines); cpl_hi = hi; cpl_lo = lo;
        frame_stb = 1'b1;
        #1;
        got_chg = live_chg;
        got_mchg = mode_chg;
        @(negedge clk);
        frame_stb = 1'b0;
        #1;
    endtask

    task automatic good_run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            frame(1'b1, 1'b1, 262, 8'h03, 8'h5A);
            check({req, " no pulse in run"}, got_chg, 1'b0);
        end
    endtask

    task automatic bad_run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            frame(1'b0, 1'b1, 262, 8'h03, 8'h5A);
            check({req, " no pulse in run"}, got_chg, 1'b0);
        end
    endtask

    task automatic t_reset();
        check("R11 live", live, 0);
        check("R11 stable", stable, 0);
        check("R11 stor_lines", stor_lines, 0);
        check("R11 stor_cpl", stor_cpl, 0);
        check("R11 stor_prog", stor_prog, 0);
        check("R6 masked at reset", sync_mode, 0);
    endtask

    task automatic t_acquire_loss();
        good_run(3, "R2");
        check("R2 not live after 3", live, 0);
        frame(1'b1, 1'b1, 262, 8'h03, 8'h5A);
        check("R2 pulse on 4th", got_chg, 1);
        check("R2 live after 4th", live, 1);
        check("R6 passes raw", sync_mode, 2'b11);
        repeat (10) @(negedge clk);
        check("R5 live held", live, 1);
        check("R5 no pulse idle", live_chg, 0);
        bad_run(5, "R3");
        check("R3 still live after 5", live, 1);
        frame(1'b0, 1'b1, 262, 8'h03, 8'h5A);
        check("R3 pulse on 6th", got_chg, 1);
        check("R3 dropped", live, 0);
        check("R6 masked", sync_mode, 0);
    endtask

    task automatic t_interrupt();
        good_run(3, "R4");
        frame(1'b0, 1'b1, 262, 8'h03, 8'h5A);
        good_run(3, "R4");
        check("R4 restart acq", live, 0);
        frame(1'b1, 1'b1, 262, 8'h03, 8'h5A);
        check("R4 acq pulse", got_chg, 1);
        bad_run(4, "R4");
        frame(1'b1, 1'b1, 262, 8'h03, 8'h5A);
        check("R4 good clears", got_chg, 0);
        bad_run(5, "R4");
        check("R4 restart loss", live, 1);
        frame(1'b0, 1'b1, 262, 8'h03, 8'h5A);
        check("R4 loss pulse", got_chg, 1);
        check("R4 lost", live, 0);
    endtask

    task automatic t_valid();
        for (int i = 0; i < 5; i++) frame(1'b1, 1'b1, 199, 8'h03, 8'h5A);
        check("R1 prog 199 invalid", live, 0);
        for (int i = 0; i < 4; i++) frame(1'b1, 1'b1, 200, 8'h03, 8'h5A);
        check("R1 prog 200 valid", live, 1);
        for (int i = 0; i < 5; i++) frame(1'b1, 1'b0, 399, 8'h03, 8'h5A);
        check("R1 intl 399 still live", live, 1);
        frame(1'b1, 1'b0, 399, 8'h03, 8'h5A);
        check("R1 intl 399 bad pulse", got_chg, 1);
        check("R1 intl 399 lost", live, 0);
        for (int i = 0; i < 4; i++) frame(1'b1, 1'b0, 400, 8'h03, 8'h5A);
        check("R1 intl 400 valid", live, 1);
    endtask

    task automatic t_stable();
        do_reset();
        frame(1'b1, 1'b0, 525, 8'hF3, 8'h5A);
        check("R8 first differs", got_mchg, 0);
        check("R8 stable 0", stable, 0);
        check("R7 cpl assembled", stor_cpl, 12'h35A);
        check("R8 lines stored", stor_lines, 525);
        frame(1'b1, 1'b0, 525, 8'hF3, 8'h5A);
        check("R9 pulse at threshold", got_mchg, 1);
        check("R9 stable", stable, 1);
        frame(1'b1, 1'b0, 525, 8'hF3, 8'h5A);
        check("R9 no repeat pulse", got_mchg, 0);
        frame(1'b1, 1'b0, 525, 8'hA3, 8'h5A);
        check("R7 high nibble ignored", stable, 1);
        check("R7 no pulse", got_mchg, 0);
        frame(1'b1, 1'b1, 100, 8'h07, 8'h11);
        check("R10 lines kept", stor_lines, 525);
        check("R10 cpl kept", stor_cpl, 12'h35A);
        check("R10 prog kept", stor_prog, 0);
        check("R10 stable kept", stable, 1);
        frame(1'b1, 1'b1, 525, 8'h03, 8'h5A);
        check("R8 prog change resets", stable, 0);
        check("R8 prog stored", stor_prog, 1);
        frame(1'b1, 1'b1, 525, 8'h03, 8'h5B);
        check("R8 cpl change resets", stable, 0);
        check("R8 cpl change no pulse", got_mchg, 0);
        frame(1'b1, 1'b1, 525, 8'h03, 8'h5B);
        check("R9 pulse again", got_mchg, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        t_reset();
        t_acquire_loss();
        t_interrupt();
        t_valid();
        t_stable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule